// File: doc/BRIEF.md
# Configurable Programmable Logic Macrocell

This block is one logic cell of a programmable logic fabric. Five product-term signals come in from an AND array outside the block. Configuration inputs choose how each one is used. A term can feed the local sum, set the XOR polarity, supply register data, act as a register clock, clock enable, clear or preset, drive the pin enable, or form the inverted foldback term. The sum also takes a cascade input from the neighbouring cell and passes the combined sum on through the cascade output. This lets a chain of cells build one wide sum.

The storage element is configurable. It can act as a D, T, JK or SR flip-flop, or as a transparent latch. All cell events are evaluated against the system clock `clk`. The cell clock is taken from one of the three global clock inputs or from a product term, and it is sampled once per system cycle. A cell clock edge is a sampled 0-to-1 change of the selected source. Clear and preset act in the cycle they are seen. They override the registered value at the outputs at once and force the stored state at the same system edge. The pin output and the buried feedback each pick, on their own, between the XOR result and the registered view. In every requirement below, a product-term index of 5 or more selects a constant 0.

Top module: `plmc_cell`

## Requirements
- R1: `casOut` is the OR of every `ptIn[i]` whose `cfgSumMask[i]` is set, ORed with `casIn` when `cfgCasEn` is 1. It is combinational.
- R2: The XOR result is `casOut` XOR a polarity bit. `cfgPolSel` selects that bit: 1 gives a constant 1, 2 gives `ptIn[cfgPolPt]`, and 0 or 3 give a constant 0. When `cfgOutReg`=0, `pinOut` shows the XOR result in the same cycle.
- R3: The register data input is chosen by `cfgDataSel`: 1 gives `ptIn[cfgDataPt]`, 2 gives `pinIn`, and 0 or 3 give the XOR result.
- R4: `cfgFfMode` sets the storage type: 0 = D, 1 = T, 2 = JK, 3 = SR, 4 = latch, and 5 to 7 = D. The second input is `ptIn[cfgAuxPt]`. For T, the state toggles when the data bit is 1. For JK, with J as the data bit and K as the second input: 00 holds, 01 clears, 10 sets and 11 toggles. For SR, with S as the data bit and R as the second input: 10 sets, 01 clears, and 00 or 11 hold.
- R5: In latch mode, the registered view follows the data input in the same cycle while the selected clock level is high (and enabled). It keeps the last value while the level is low.
- R6: `cfgClkSel` values 0 to 2 select `gClk[cfgClkSel]`, and 3 selects `ptIn[cfgClkPt]`. In the edge modes, the state changes only at a system edge where the selected level is 1 and was 0 at the previous system edge.
- R7: When `cfgCeEn`=1 and a global clock is selected, clock edges are ignored while `ptIn[cfgCePt]` is 0. With a product-term clock, `cfgCeEn` has no effect.
- R8: `cfgClrSel` picks the clear source: 0 = off, 1 = `gClr`, 2 = `ptIn[cfgClrPt]`, 3 = either. An active clear forces the registered view to 0 in the same cycle and the state to 0 at the next system edge.
- R9: When `cfgPreEn`=1, `ptIn[cfgPrePt]` is a preset that forces the registered view and the state to 1. A clear that is active at the same time wins.
- R10: `cfgOutReg` and `cfgFbReg` each select, on their own, between the XOR result (0) and the registered view (1). The first selection drives `pinOut` and the second drives `fbOut`.
- R11: `foldOut` equals the inverse of `ptIn[cfgFoldPt]`.
- R12: `pinOe` is chosen by `cfgOeSel`: 0 = `gOe[0]`, 1 = not `gOe[0]`, 2 = `gOe[1]`, 3 = not `gOe[1]`, 4 = `ptIn[cfgOePt]`, and 5 to 7 = 0.
- R13: While `rstN` is low, the state and the sampled clock level are cleared at each system edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| ptIn | input | 5 | Product-term inputs |
| casIn | input | 1 | Cascade sum from the neighbouring cell |
| gClk | input | 3 | Global clock levels |
| gClr | input | 1 | Global clear |
| gOe | input | 2 | Global output-enable pins |
| pinIn | input | 1 | Pin input for register data |
| cfgSumMask | input | 5 | Product terms ORed into the sum |
| cfgCasEn | input | 1 | Include the cascade input in the sum |
| cfgPolSel | input | 2 | Polarity source |
| cfgPolPt | input | 3 | Polarity product-term index |
| cfgDataSel | input | 2 | Register data source |
| cfgDataPt | input | 3 | Data product-term index |
| cfgFfMode | input | 3 | Storage type |
| cfgAuxPt | input | 3 | Index of the second JK/SR input |
| cfgClkSel | input | 2 | Clock source |
| cfgClkPt | input | 3 | Clock product-term index |
| cfgCeEn | input | 1 | Clock enable on |
| cfgCePt | input | 3 | Clock-enable product-term index |
| cfgClrSel | input | 2 | Clear source |
| cfgClrPt | input | 3 | Clear product-term index |
| cfgPreEn | input | 1 | Preset on |
| cfgPrePt | input | 3 | Preset product-term index |
| cfgOutReg | input | 1 | Pin output registered |
| cfgFbReg | input | 1 | Feedback registered |
| cfgOeSel | input | 3 | Output-enable source |
| cfgOePt | input | 3 | Output-enable product-term index |
| cfgFoldPt | input | 3 | Foldback product-term index |
| pinOut | output | 1 | Pin data |
| pinOe | output | 1 | Pin output enable |
| fbOut | output | 1 | Buried feedback |
| foldOut | output | 1 | Inverted foldback term |
| casOut | output | 1 | Cascade sum out |

## Verification
Four functions can coincide in one cycle: a clear, a preset, a clock edge and an open latch gate. Clear and preset can also target the same state in the same cycle. The bench provokes this in two ways. It drives both from product terms in one directed cycle, and it picks clear, preset and clock sources at random so that edges often land together with a clear or a preset. Each coincidence is judged against a bench model. In that model, clear is applied first, then preset, then latch transparency, then the edge update. The model checks the registered view in the same cycle and the state after the edge.

// File: rtl/plmc_pkg.sv
package plmc_pkg;

  typedef enum logic [2:0] {
    FF_D     = 3'd0,
    FF_T     = 3'd1,
    FF_JK    = 3'd2,
    FF_SR    = 3'd3,
    FF_LATCH = 3'd4
  } ffMode_e;

  typedef enum logic [1:0] {
    CLR_OFF  = 2'd0,
    CLR_GLB  = 2'd1,
    CLR_TERM = 2'd2,
    CLR_BOTH = 2'd3
  } clrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;      // qualified rising edge of the cell clock
    logic gateOpen;  // latch gate level (qualified)
    logic clrAct;    // clear active this cycle
    logic preAct;    // preset active this cycle
  } plmc_strobe_t;

endpackage

// File: rtl/plmc_ctrl.sv
module plmc_ctrl
  import plmc_pkg::*;
#(
  parameter  int NUM_PT   = 5,
  parameter  int NUM_GCLK = 3,
  parameter  int NUM_GOE  = 2,
  localparam int IDX_W    = $clog2(NUM_PT),
  localparam int CSEL_W   = $clog2(NUM_GCLK + 1),
  localparam int OESEL_W  = $clog2(2 * NUM_GOE + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PT-1:0]   ptIn,
  input  logic [NUM_GCLK-1:0] gClk,
  input  logic                gClr,
  input  logic [NUM_GOE-1:0]  gOe,
  input  logic [CSEL_W-1:0]   cfgClkSel,
  input  logic [IDX_W-1:0]    cfgClkPt,
  input  logic                cfgCeEn,
  input  logic [IDX_W-1:0]    cfgCePt,
  input  logic [1:0]          cfgClrSel,
  input  logic [IDX_W-1:0]    cfgClrPt,
  input  logic                cfgPreEn,
  input  logic [IDX_W-1:0]    cfgPrePt,
  input  logic [OESEL_W-1:0]  cfgOeSel,
  input  logic [IDX_W-1:0]    cfgOePt,
  output plmc_strobe_t        strb,
  output logic                pinOe
);

  function automatic logic pick(input logic [NUM_PT-1:0] v, input logic [IDX_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_PT; k++) begin
      if (idx == IDX_W'(k)) r = v[k];
    end
    return r;
  endfunction

  logic clkLvl;
  logic clkPrev;
  logic globalClk;
  logic ceOk;
  logic clrTerm;

  // clock source selection
  always_comb begin
    clkLvl = 1'b0;
    for (int k = 0; k < NUM_GCLK; k++) begin
      if (int'(cfgClkSel) == k) clkLvl = gClk[k];
    end
    if (int'(cfgClkSel) == NUM_GCLK) clkLvl = pick(ptIn, cfgClkPt);
  end

  assign globalClk = int'(cfgClkSel) < NUM_GCLK;
  assign ceOk      = !(cfgCeEn && globalClk) || pick(ptIn, cfgCePt);

  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkLvl;
  end

  // clear / preset
  assign clrTerm = pick(ptIn, cfgClrPt);

  always_comb begin
    strb.tick     = clkLvl && !clkPrev && ceOk;
    strb.gateOpen = clkLvl && ceOk;
    unique case (clrSel_e'(cfgClrSel))
      CLR_GLB:  strb.clrAct = gClr;
      CLR_TERM: strb.clrAct = clrTerm;
      CLR_BOTH: strb.clrAct = gClr || clrTerm;
      default:  strb.clrAct = 1'b0;
    endcase
    strb.preAct = cfgPreEn && pick(ptIn, cfgPrePt);
  end

  // output enable selection
  always_comb begin
    pinOe = 1'b0;
    for (int k = 0; k < 2 * NUM_GOE; k++) begin
      if (int'(cfgOeSel) == k) pinOe = gOe[k / 2] ^ k[0];
    end
    if (int'(cfgOeSel) == 2 * NUM_GOE) pinOe = pick(ptIn, cfgOePt);
  end

endmodule

// File: rtl/plmc_datapath.sv
module plmc_datapath
  import plmc_pkg::*;
#(
  parameter  int NUM_PT = 5,
  localparam int IDX_W  = $clog2(NUM_PT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_PT-1:0] ptIn,
  input  logic              casIn,
  input  logic              pinIn,
  input  logic [NUM_PT-1:0] cfgSumMask,
  input  logic              cfgCasEn,
  input  logic [1:0]        cfgPolSel,
  input  logic [IDX_W-1:0]  cfgPolPt,
  input  logic [1:0]        cfgDataSel,
  input  logic [IDX_W-1:0]  cfgDataPt,
  input  logic [2:0]        cfgFfMode,
  input  logic [IDX_W-1:0]  cfgAuxPt,
  input  logic              cfgOutReg,
  input  logic              cfgFbReg,
  input  logic [IDX_W-1:0]  cfgFoldPt,
  input  plmc_strobe_t      strb,
  output logic              casOut,
  output logic              pinOut,
  output logic              fbOut,
  output logic              foldOut,
  output logic              stateQ
);

  function automatic logic pick(input logic [NUM_PT-1:0] v, input logic [IDX_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_PT; k++) begin
      if (idx == IDX_W'(k)) r = v[k];
    end
    return r;
  endfunction

  logic    sumTerm;
  logic    polBit;
  logic    xorOut;
  logic    dIn;
  logic    auxIn;
  logic    edgeNext;
  logic    isLatch;
  logic    regView;
  ffMode_e modeS;

  assign sumTerm = (|(ptIn & cfgSumMask)) | (cfgCasEn & casIn);
  assign casOut  = sumTerm;

  always_comb begin
    unique case (cfgPolSel)
      2'd1:    polBit = 1'b1;
      2'd2:    polBit = pick(ptIn, cfgPolPt);
      default: polBit = 1'b0;
    endcase
  end

  assign xorOut = sumTerm ^ polBit;

  always_comb begin
    unique case (cfgDataSel)
      2'd1:    dIn = pick(ptIn, cfgDataPt);
      2'd2:    dIn = pinIn;
      default: dIn = xorOut;
    endcase
  end

  assign auxIn   = pick(ptIn, cfgAuxPt);
  assign modeS   = ffMode_e'(cfgFfMode);
  assign isLatch = (modeS == FF_LATCH);

  // next state on a qualified clock edge
  always_comb begin
    unique case (modeS)
      FF_T:    edgeNext = stateQ ^ dIn;
      FF_JK: begin
        unique case ({dIn, auxIn})
          2'b01:   edgeNext = 1'b0;
          2'b10:   edgeNext = 1'b1;
          2'b11:   edgeNext = !stateQ;
          default: edgeNext = stateQ;
        endcase
      end
      FF_SR: begin
        unique case ({dIn, auxIn})
          2'b10:   edgeNext = 1'b1;
          2'b01:   edgeNext = 1'b0;
          default: edgeNext = stateQ;
        endcase
      end
      default: edgeNext = dIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              stateQ <= 1'b0;
    else if (strb.clrAct)   stateQ <= 1'b0;
    else if (strb.preAct)   stateQ <= 1'b1;
    else if (isLatch) begin
      if (strb.gateOpen)    stateQ <= dIn;
    end
    else if (strb.tick)     stateQ <= edgeNext;
  end

  // registered view: clear and preset override at once, latch is transparent
  always_comb begin
    if (strb.clrAct)                  regView = 1'b0;
    else if (strb.preAct)             regView = 1'b1;
    else if (isLatch && strb.gateOpen) regView = dIn;
    else                              regView = stateQ;
  end

  assign pinOut  = cfgOutReg ? regView : xorOut;
  assign fbOut   = cfgFbReg  ? regView : xorOut;
  assign foldOut = !pick(ptIn, cfgFoldPt);

endmodule

// File: rtl/plmc_cell.sv
module plmc_cell
  import plmc_pkg::*;
#(
  parameter  int NUM_PT   = 5,
  parameter  int NUM_GCLK = 3,
  parameter  int NUM_GOE  = 2,
  localparam int IDX_W    = $clog2(NUM_PT),
  localparam int CSEL_W   = $clog2(NUM_GCLK + 1),
  localparam int OESEL_W  = $clog2(2 * NUM_GOE + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PT-1:0]   ptIn,
  input  logic                casIn,
  input  logic [NUM_GCLK-1:0] gClk,
  input  logic                gClr,
  input  logic [NUM_GOE-1:0]  gOe,
  input  logic                pinIn,
  input  logic [NUM_PT-1:0]   cfgSumMask,
  input  logic                cfgCasEn,
  input  logic [1:0]          cfgPolSel,
  input  logic [IDX_W-1:0]    cfgPolPt,
  input  logic [1:0]          cfgDataSel,
  input  logic [IDX_W-1:0]    cfgDataPt,
  input  logic [2:0]          cfgFfMode,
  input  logic [IDX_W-1:0]    cfgAuxPt,
  input  logic [CSEL_W-1:0]   cfgClkSel,
  input  logic [IDX_W-1:0]    cfgClkPt,
  input  logic                cfgCeEn,
  input  logic [IDX_W-1:0]    cfgCePt,
  input  logic [1:0]          cfgClrSel,
  input  logic [IDX_W-1:0]    cfgClrPt,
  input  logic                cfgPreEn,
  input  logic [IDX_W-1:0]    cfgPrePt,
  input  logic                cfgOutReg,
  input  logic                cfgFbReg,
  input  logic [OESEL_W-1:0]  cfgOeSel,
  input  logic [IDX_W-1:0]    cfgOePt,
  input  logic [IDX_W-1:0]    cfgFoldPt,
  output logic                pinOut,
  output logic                pinOe,
  output logic                fbOut,
  output logic                foldOut,
  output logic                casOut
);

  plmc_strobe_t strb;
  logic         stateQ;

  plmc_ctrl #(.NUM_PT(NUM_PT), .NUM_GCLK(NUM_GCLK), .NUM_GOE(NUM_GOE)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ptIn      (ptIn),
    .gClk      (gClk),
    .gClr      (gClr),
    .gOe       (gOe),
    .cfgClkSel (cfgClkSel),
    .cfgClkPt  (cfgClkPt),
    .cfgCeEn   (cfgCeEn),
    .cfgCePt   (cfgCePt),
    .cfgClrSel (cfgClrSel),
    .cfgClrPt  (cfgClrPt),
    .cfgPreEn  (cfgPreEn),
    .cfgPrePt  (cfgPrePt),
    .cfgOeSel  (cfgOeSel),
    .cfgOePt   (cfgOePt),
    .strb      (strb),
    .pinOe     (pinOe)
  );

  plmc_datapath #(.NUM_PT(NUM_PT)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ptIn       (ptIn),
    .casIn      (casIn),
    .pinIn      (pinIn),
    .cfgSumMask (cfgSumMask),
    .cfgCasEn   (cfgCasEn),
    .cfgPolSel  (cfgPolSel),
    .cfgPolPt   (cfgPolPt),
    .cfgDataSel (cfgDataSel),
    .cfgDataPt  (cfgDataPt),
    .cfgFfMode  (cfgFfMode),
    .cfgAuxPt   (cfgAuxPt),
    .cfgOutReg  (cfgOutReg),
    .cfgFbReg   (cfgFbReg),
    .cfgFoldPt  (cfgFoldPt),
    .strb       (strb),
    .casOut     (casOut),
    .pinOut     (pinOut),
    .fbOut      (fbOut),
    .foldOut    (foldOut),
    .stateQ     (stateQ)
  );

endmodule

// File: rtl/plmc_cell_chk.sv
module plmc_cell_chk
  import plmc_pkg::*;
#(
  parameter  int NUM_PT  = 5,
  parameter  int NUM_GOE = 2,
  localparam int IDX_W   = $clog2(NUM_PT),
  localparam int OESEL_W = $clog2(2 * NUM_GOE + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_PT-1:0]  ptIn,
  input logic [NUM_GOE-1:0] gOe,
  input logic [NUM_PT-1:0]  cfgSumMask,
  input logic               cfgCasEn,
  input logic [2:0]         cfgFfMode,
  input logic               cfgOutReg,
  input logic [OESEL_W-1:0] cfgOeSel,
  input logic [IDX_W-1:0]   cfgFoldPt,
  input logic               pinOut,
  input logic               pinOe,
  input logic               foldOut,
  input logic               casOut,
  input logic               tick,
  input logic               clrAct,
  input logic               preAct,
  input logic               stateQ
);

  p_empty_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSumMask == '0 && !cfgCasEn) |-> !casOut);

  p_hold_no_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !clrAct && !preAct && cfgFfMode != FF_LATCH) |=> $stable(stateQ));

  p_clear_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrAct |=> !stateQ);

  p_preset_state_r9: assert property (@(posedge clk) disable iff (!rstN)
    (preAct && !clrAct) |=> stateQ);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrAct && preAct && cfgOutReg) |-> !pinOut);

  p_fold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFoldPt == '0) |-> (foldOut == !ptIn[0]));

  p_oe_pin0_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOeSel == '0) |-> (pinOe == gOe[0]));

  p_reset_r13: assert property (@(posedge clk)
    !rstN |=> !stateQ);

endmodule

bind plmc_cell plmc_cell_chk #(.NUM_PT(NUM_PT), .NUM_GOE(NUM_GOE)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .ptIn       (ptIn),
  .gOe        (gOe),
  .cfgSumMask (cfgSumMask),
  .cfgCasEn   (cfgCasEn),
  .cfgFfMode  (cfgFfMode),
  .cfgOutReg  (cfgOutReg),
  .cfgOeSel   (cfgOeSel),
  .cfgFoldPt  (cfgFoldPt),
  .pinOut     (pinOut),
  .pinOe      (pinOe),
  .foldOut    (foldOut),
  .casOut     (casOut),
  .tick       (strb.tick),
  .clrAct     (strb.clrAct),
  .preAct     (strb.preAct),
  .stateQ     (stateQ)
);

// File: tb/plmc_cell_tb.sv
`timescale 1ns/1ps
module plmc_cell_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] ptIn;
  logic       casIn;
  logic [2:0] gClk;
  logic       gClr;
  logic [1:0] gOe;
  logic       pinIn;
  logic [4:0] cfgSumMask;
  logic       cfgCasEn;
  logic [1:0] cfgPolSel;
  logic [2:0] cfgPolPt;
  logic [1:0] cfgDataSel;
  logic [2:0] cfgDataPt;
  logic [2:0] cfgFfMode;
  logic [2:0] cfgAuxPt;
  logic [1:0] cfgClkSel;
  logic [2:0] cfgClkPt;
  logic       cfgCeEn;
  logic [2:0] cfgCePt;
  logic [1:0] cfgClrSel;
  logic [2:0] cfgClrPt;
  logic       cfgPreEn;
  logic [2:0] cfgPrePt;
  logic       cfgOutReg;
  logic       cfgFbReg;
  logic [2:0] cfgOeSel;
  logic [2:0] cfgOePt;
  logic [2:0] cfgFoldPt;
  logic       pinOut, pinOe, fbOut, foldOut, casOut;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  logic mQ, mPrev;

  always #2.5 clk = ~clk;

  plmc_cell dut_i (
    .clk(clk), .rstN(rstN), .ptIn(ptIn), .casIn(casIn), .gClk(gClk), .gClr(gClr),
    .gOe(gOe), .pinIn(pinIn), .cfgSumMask(cfgSumMask), .cfgCasEn(cfgCasEn),
    .cfgPolSel(cfgPolSel), .cfgPolPt(cfgPolPt), .cfgDataSel(cfgDataSel),
    .cfgDataPt(cfgDataPt), .cfgFfMode(cfgFfMode), .cfgAuxPt(cfgAuxPt),
    .cfgClkSel(cfgClkSel), .cfgClkPt(cfgClkPt), .cfgCeEn(cfgCeEn), .cfgCePt(cfgCePt),
    .cfgClrSel(cfgClrSel), .cfgClrPt(cfgClrPt), .cfgPreEn(cfgPreEn), .cfgPrePt(cfgPrePt),
    .cfgOutReg(cfgOutReg), .cfgFbReg(cfgFbReg), .cfgOeSel(cfgOeSel), .cfgOePt(cfgOePt),
    .cfgFoldPt(cfgFoldPt), .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut),
    .foldOut(foldOut), .casOut(casOut)
  );

  // ---------------- reference model ----------------
  function automatic logic pk(input logic [4:0] v, input logic [2:0] i);
    return (i < 3'd5) ? v[i] : 1'b0;
  endfunction

  function automatic logic eSum();
    return (|(ptIn & cfgSumMask)) | (cfgCasEn & casIn);
  endfunction

  function automatic logic eXor();
    logic p;
    p = (cfgPolSel == 2'd1) ? 1'b1 : (cfgPolSel == 2'd2) ? pk(ptIn, cfgPolPt) : 1'b0;
    return eSum() ^ p;
  endfunction

  function automatic logic eD();
    return (cfgDataSel == 2'd1) ? pk(ptIn, cfgDataPt) : (cfgDataSel == 2'd2) ? pinIn : eXor();
  endfunction

  function automatic logic eLvl();
    return (cfgClkSel == 2'd3) ? pk(ptIn, cfgClkPt) : gClk[cfgClkSel];
  endfunction

  function automatic logic eCe();
    return (cfgCeEn && cfgClkSel != 2'd3) ? pk(ptIn, cfgCePt) : 1'b1;
  endfunction

  function automatic logic eClr();
    logic t;
    t = pk(ptIn, cfgClrPt);
    case (cfgClrSel)
      2'd1: return gClr;
      2'd2: return t;
      2'd3: return gClr | t;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ePre();
    return cfgPreEn & pk(ptIn, cfgPrePt);
  endfunction

  function automatic logic eView();
    if (eClr()) return 1'b0;
    if (ePre()) return 1'b1;
    if (cfgFfMode == 3'd4 && eLvl() && eCe()) return eD();
    return mQ;
  endfunction

  function automatic logic eNext();
    logic d, a;
    d = eD();
    a = pk(ptIn, cfgAuxPt);
    if (eClr()) return 1'b0;
    if (ePre()) return 1'b1;
    if (cfgFfMode == 3'd4) return (eLvl() && eCe()) ? d : mQ;
    if (!(eLvl() && !mPrev && eCe())) return mQ;
    case (cfgFfMode)
      3'd1: return mQ ^ d;
      3'd2: return (d && a) ? !mQ : d ? 1'b1 : a ? 1'b0 : mQ;
      3'd3: return (d && !a) ? 1'b1 : (!d && a) ? 1'b0 : mQ;
      default: return d;
    endcase
  endfunction

  function automatic logic eOe();
    case (cfgOeSel)
      3'd0: return gOe[0];
      3'd1: return !gOe[0];
      3'd2: return gOe[1];
      3'd3: return !gOe[1];
      3'd4: return pk(ptIn, cfgOePt);
      default: return 1'b0;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string regTag();
    if (eClr()) return "R8";
    if (ePre()) return "R9";
    if (cfgFfMode == 3'd4) return "R5";
    if (cfgDataSel != 2'd0) return "R3";
    return "R6";
  endfunction

  task automatic checkOut();
    chk("R1", casOut, eSum());
    chk(cfgOutReg ? regTag() : "R2", pinOut, cfgOutReg ? eView() : eXor());
    chk(cfgFbReg ? "R10" : "R2", fbOut, cfgFbReg ? eView() : eXor());
    chk("R11", foldOut, !pk(ptIn, cfgFoldPt));
    chk("R12", pinOe, eOe());
  endtask

  // called just after a falling edge with inputs set; returns at the next falling edge
  task automatic step();
    logic nQ, nP;
    #1;
    checkOut();
    nQ = eNext();
    nP = eLvl();
    @(posedge clk);
    mQ = nQ;
    mPrev = nP;
    @(negedge clk);
  endtask

  task automatic cfgClear();
    cfgSumMask = '0; cfgCasEn = 0; cfgPolSel = 0; cfgPolPt = 0; cfgDataSel = 0;
    cfgDataPt = 0; cfgFfMode = 0; cfgAuxPt = 0; cfgClkSel = 0; cfgClkPt = 0;
    cfgCeEn = 0; cfgCePt = 0; cfgClrSel = 0; cfgClrPt = 0; cfgPreEn = 0;
    cfgPrePt = 0; cfgOutReg = 0; cfgFbReg = 0; cfgOeSel = 0; cfgOePt = 0; cfgFoldPt = 0;
  endtask

  task automatic inClear();
    ptIn = 0; casIn = 0; gClk = 0; gClr = 0; gOe = 0; pinIn = 0;
  endtask

  initial begin
    void'($urandom(32'd1977));
    rstN = 1'b0;
    cfgClear();
    inClear();
    cfgOutReg = 1; cfgFbReg = 1;
    mQ = 0; mPrev = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R13: state cleared by reset
    chk("R13", fbOut, 1'b0);
    chk("R13", pinOut, 1'b0);
    @(negedge clk);

    // R7: clock enable low ignores an edge on global clock 0
    cfgClear(); cfgFbReg = 1; cfgDataSel = 2'd2; cfgCeEn = 1; cfgCePt = 3'd2;
    inClear(); pinIn = 1;
    step();
    gClk[0] = 1; ptIn[2] = 0;
    step();
    chk("R7", fbOut, 1'b0);
    gClk[0] = 0;
    step();
    gClk[0] = 1; ptIn[2] = 1;
    step();
    chk("R6", fbOut, 1'b1);
    // R7: enable ignored with product-term clock (pt3), pt2 low
    cfgClkSel = 2'd3; cfgClkPt = 3'd3; gClk = 0; ptIn = 0; pinIn = 0;
    step();
    ptIn = 5'b01000;
    step();
    chk("R7", fbOut, 1'b0);

    // R5: transparent latch on global clock 1
    cfgClear(); cfgOutReg = 1; cfgFbReg = 1; cfgFfMode = 3'd4; cfgClkSel = 2'd1;
    cfgDataSel = 2'd2;
    inClear(); gClk[1] = 1; pinIn = 1;
    #1; chk("R5", pinOut, 1'b1);
    step();
    gClk[1] = 1; pinIn = 0;
    #1; chk("R5", pinOut, 1'b0);
    step();
    pinIn = 1;
    step();
    gClk[1] = 0; pinIn = 0;
    #1; chk("R5", pinOut, 1'b1);
    step();
    chk("R5", fbOut, 1'b1);

    // R4: JK on product-term clock pt4, J=pt0, K=pt1
    cfgClear(); cfgFbReg = 1; cfgFfMode = 3'd2; cfgClkSel = 2'd3; cfgClkPt = 3'd4;
    cfgDataSel = 2'd1; cfgDataPt = 3'd0; cfgAuxPt = 3'd1;
    inClear();
    step();
    ptIn = 5'b10011; step(); chk("R4", fbOut, 1'b0);   // toggle 1 -> 0
    ptIn = 5'b00000; step();
    ptIn = 5'b10011; step(); chk("R4", fbOut, 1'b1);   // toggle 0 -> 1
    ptIn = 5'b00000; step();
    ptIn = 5'b10010; step(); chk("R4", fbOut, 1'b0);   // K clears
    ptIn = 5'b00000; step();
    ptIn = 5'b10001; step(); chk("R4", fbOut, 1'b1);   // J sets
    ptIn = 5'b00001; step(); chk("R6", fbOut, 1'b1);   // no edge: hold

    // R9: clear (pt0) and preset (pt1) together, clear wins
    cfgClear(); cfgOutReg = 1; cfgFbReg = 1; cfgClrSel = 2'd2; cfgClrPt = 3'd0;
    cfgPreEn = 1; cfgPrePt = 3'd1;
    inClear(); ptIn = 5'b00011;
    #1; chk("R9", pinOut, 1'b0);
    step();
    chk("R8", fbOut, 1'b0);
    ptIn = 5'b00010;
    #1; chk("R9", pinOut, 1'b1);
    step();
    ptIn = 5'b00000;
    #1; chk("R9", fbOut, 1'b1);
    step();

    // R8: global clear or term clear with select 3
    cfgClrSel = 2'd3; cfgPreEn = 0; gClr = 1;
    #1; chk("R8", pinOut, 1'b0);
    step();
    gClr = 0;
    #1; chk("R8", fbOut, 1'b0);
    step();

    // R10: independent output and feedback selection
    cfgClear(); cfgOutReg = 0; cfgFbReg = 1; cfgSumMask = 5'b00100; inClear(); ptIn = 5'b00100;
    #1; chk("R10", pinOut, 1'b1); chk("R10", fbOut, 1'b0);
    step();

    // constrained random phases
    for (int ph = 0; ph < 80; ph++) begin
      cfgSumMask = 5'($urandom); cfgCasEn = 1'($urandom);
      cfgPolSel = 2'($urandom); cfgPolPt = 3'($urandom % 7);
      cfgDataSel = 2'($urandom); cfgDataPt = 3'($urandom % 7);
      cfgFfMode = 3'($urandom % 6); cfgAuxPt = 3'($urandom % 7);
      cfgClkSel = 2'($urandom); cfgClkPt = 3'($urandom % 7);
      cfgCeEn = 1'($urandom); cfgCePt = 3'($urandom % 7);
      cfgClrSel = 2'($urandom); cfgClrPt = 3'($urandom % 7);
      cfgPreEn = 1'($urandom); cfgPrePt = 3'($urandom % 7);
      cfgOutReg = 1'($urandom); cfgFbReg = 1'($urandom);
      cfgOeSel = 3'($urandom); cfgOePt = 3'($urandom % 7); cfgFoldPt = 3'($urandom % 7);
      for (int c = 0; c < 40; c++) begin
        ptIn = 5'($urandom); casIn = 1'($urandom); gClk = 3'($urandom);
        gClr = ($urandom % 6 == 0); gOe = 2'($urandom); pinIn = 1'($urandom);
        step();
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule